// File: doc/BRIEF.md
# Configurable external interrupt edge detector

This block watches six external interrupt pins and keeps one request flag per pin. Each pin is first brought into the system clock domain through a synchronizer. A comparison of the current synchronized sample with the previous one then finds its transitions.

Channels 0 and 1 each have one select bit. Clearing the bit makes the channel level sensitive, active low. Setting it makes channel 0 trigger on a falling edge and channel 1 trigger on both edges. Channels 2 to 5 each have a two-bit sensitivity field, and all four fields sit in one shared configuration register. Both-edge sensitivity lets software time pulse widths, for example on a remote-control input.

In an edge mode, a qualifying transition sets a sticky request. The request stays set until its clear input is pulsed, which happens on acknowledge or from software. In level mode, the request simply shows the inverted synchronized pin. Prioritisation and vectoring belong to the logic that consumes the requests.

Top module: `extirq_detect`

## Requirements
- R1: After reset, every request output is 0, every channel is in level mode, and the select bits and the sensitivity register read as zero.
- R2: Channel n (n = 2..5) takes its mode from bits [2(n-2)+1 : 2(n-2)] of the sensitivity register, written through `ext_cfg_wdata` when `ext_cfg_we` is high. The codes are: 00 level active low, 01 rising edge, 10 falling edge, 11 both edges.
- R3: Select bit 0 (`sel_wdata[0]`, written when `sel_we` is high) controls channel 0. When it is 0, the channel is level sensitive active low. When it is 1, the channel is set by a falling edge only.
- R4: Select bit 1 (`sel_wdata[1]`) controls channel 1. When it is 0, the channel is level sensitive active low. When it is 1, the channel is set by both rising and falling edges.
- R5: In level mode, the request equals the inverted synchronized pin, and the channel's clear input has no effect on it.
- R6: In an edge mode, a set request stays high until a one-cycle pulse on its clear input, whatever the pin does afterwards. The request is low in the cycle after that pulse.
- R7: In an edge mode, if a qualifying edge and a clear arrive in the same cycle, the request ends up set.
- R8: A pin change that is sampled at a rising clock edge becomes visible at the request after the third rising edge in an edge mode, and after the second in level mode. It is not visible earlier.
- R9: In an edge mode, a transition in the direction that the mode does not select leaves the request low.
- R10: A pin that is held high through reset and afterwards produces no request in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Raw external interrupt pins, asynchronous |
| ext_cfg_we | input | 1 | Write strobe for the sensitivity register of channels 2 to 5 |
| ext_cfg_wdata | input | 8 | Sensitivity register write data, two bits per channel |
| sel_we | input | 1 | Write strobe for the channel 0 and 1 select bits |
| sel_wdata | input | 2 | Select bit write data, bit 0 for channel 0 and bit 1 for channel 1 |
| clr_i | input | 6 | Per-channel one-cycle request clear |
| req_o | output | 6 | Per-channel request flags |

## Verification
The assertions assume three things about the inputs:
- Each clear is a single-cycle pulse.
- The pins are already clean digital levels.
- Configuration writes arrive only between pin activity.

Under these assumptions, a rise of a request in an edge mode must follow a detected transition, and a set request must survive until cleared. The level-mode check also assumes the default two synchronizer stages.

The bench drives pins, clears and writes only at falling clock edges. It holds each pin level for several cycles, and returns every channel to pin high, request clear and level mode before the next scenario. The same-cycle race is staged by placing the clear pulse on the exact cycle in which the transition is detected.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NUM_CH   = 6;
    localparam int NUM_SEL  = 2;
    localparam int NUM_EXT  = NUM_CH - NUM_SEL;
    localparam int EXT_BITS = 2 * NUM_EXT;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_FALL  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

    typedef sense_e [NUM_CH-1:0] sense_vec_t;

    // Mode of a channel from the select bits and the shared sensitivity field
    function automatic sense_e chan_sense(input int ch,
                                          input logic [EXT_BITS-1:0] ext,
                                          input logic [NUM_SEL-1:0] sel);
        sense_e m;
        if (ch == 0) begin
            m = sel[0] ? SENSE_FALL : SENSE_LEVEL;
        end else if (ch == 1) begin
            m = sel[1] ? SENSE_BOTH : SENSE_LEVEL;
        end else begin
            m = sense_e'(ext[2*(ch-NUM_SEL) +: 2]);
        end
        return m;
    endfunction

    // Whether a transition between two samples qualifies under a mode
    function automatic logic edge_qualifies(input sense_e m,
                                            input logic prev,
                                            input logic cur);
        logic rise;
        logic fall;
        rise = ~prev & cur;
        fall = prev & ~cur;
        case (m)
            SENSE_RISE: return rise;
            SENSE_FALL: return fall;
            SENSE_BOTH: return rise | fall;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '1;
            end
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/extirq_cfg.sv
module extirq_cfg
    import extirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_we_i,
    input  logic [EXT_BITS-1:0] ext_wdata_i,
    input  logic                sel_we_i,
    input  logic [NUM_SEL-1:0]  sel_wdata_i,
    output sense_vec_t          sense_o
);

    logic [EXT_BITS-1:0] ext_q;
    logic [NUM_SEL-1:0]  sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
            sel_q <= '0;
        end else begin
            if (ext_we_i) begin
                ext_q <= ext_wdata_i;
            end
            if (sel_we_i) begin
                sel_q <= sel_wdata_i;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
        assign sense_o[c] = chan_sense(c, ext_q, sel_q);
    end

endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
    import extirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e sense_i,
    input  logic   sync_i,
    input  logic   clr_i,
    output logic   hit_o,
    output logic   req_o
);

    logic prev_q;
    logic flag_q;

    assign hit_o = edge_qualifies(sense_i, prev_q, sync_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= sync_i;
            if (sense_i == SENSE_LEVEL) begin
                flag_q <= 1'b0;
            end else if (hit_o) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign req_o = (sense_i == SENSE_LEVEL) ? ~sync_i : flag_q;

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   pin_i,
    input  logic                ext_cfg_we,
    input  logic [EXT_BITS-1:0] ext_cfg_wdata,
    input  logic                sel_we,
    input  logic [NUM_SEL-1:0]  sel_wdata,
    input  logic [NUM_CH-1:0]   clr_i,
    output logic [NUM_CH-1:0]   req_o
);

    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] edge_hit;
    sense_vec_t        sense;

    extirq_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    extirq_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .ext_we_i    (ext_cfg_we),
        .ext_wdata_i (ext_cfg_wdata),
        .sel_we_i    (sel_we),
        .sel_wdata_i (sel_wdata),
        .sense_o     (sense)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        extirq_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .sense_i (sense[c]),
            .sync_i  (pin_sync[c]),
            .clr_i   (clr_i[c]),
            .hit_o   (edge_hit[c]),
            .req_o   (req_o[c])
        );
    end

endmodule

// File: rtl/extirq_detect_chk.sv
module extirq_detect_chk
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] pin_i,
    input logic [NUM_CH-1:0] clr_i,
    input logic [NUM_CH-1:0] req_o,
    input logic [NUM_CH-1:0] edge_hit,
    input sense_vec_t        sense
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (req_o == '0)); // R1

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sense[c] != SENSE_LEVEL && req_o[c] && !clr_i[c])
            |=> (req_o[c] || !$stable(sense[c]))); // R6

        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (sense[c] != SENSE_LEVEL && clr_i[c] && !edge_hit[c])
            |=> (!req_o[c] || !$stable(sense[c]))); // R6

        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
            (sense[c] != SENSE_LEVEL && edge_hit[c])
            |=> (req_o[c] || !$stable(sense[c]))); // R7

        AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            ($rose(req_o[c]) && sense[c] != SENSE_LEVEL && $stable(sense[c]))
            |-> $past(edge_hit[c])); // R9

        if (SYNC_STAGES == 2) begin : g_lvl
            AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3 && sense[c] == SENSE_LEVEL)
                |-> (req_o[c] == !$past(pin_i[c], 2))); // R5
        end
    end

endmodule

bind extirq_detect extirq_detect_chk #(
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (pin_i),
    .clr_i    (clr_i),
    .req_o    (req_o),
    .edge_hit (edge_hit),
    .sense    (sense)
);

// File: tb/extirq_detect_bench.sv
`timescale 1ns/1ps
module extirq_detect_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] pin_i = 6'h3F;
    logic       ext_cfg_we = 1'b0;
    logic [7:0] ext_cfg_wdata = '0;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = '0;
    logic [5:0] clr_i = '0;
    logic [5:0] req_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    extirq_detect u_extirq_detect (
        .clk           (clk),
        .rst           (rst),
        .pin_i         (pin_i),
        .ext_cfg_we    (ext_cfg_we),
        .ext_cfg_wdata (ext_cfg_wdata),
        .sel_we        (sel_we),
        .sel_wdata     (sel_wdata),
        .clr_i         (clr_i),
        .req_o         (req_o)
    );

    task automatic check(input string tag, input logic [5:0] exp);
        checks++;
        if (req_o !== exp) begin
            failures++;
            $display("FAIL %s req_o=%b expected=%b", tag, req_o, exp);
        end
    endtask

    // wait n rising edges, then stop at the next falling edge
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ext(input logic [7:0] v);
        ext_cfg_wdata = v; ext_cfg_we = 1'b1;
        @(negedge clk);
        ext_cfg_we = 1'b0;
    endtask

    task automatic wr_sel(input logic [1:0] v);
        sel_wdata = v; sel_we = 1'b1;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic pulse_clr(input int ch);
        clr_i[ch] = 1'b1;
        @(negedge clk);
        clr_i[ch] = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", 6'h00);
        edges(6);
        check("R10 idle high after reset", 6'h00);
    endtask

    task automatic t_level;
        pin_i[2] = 1'b0;
        edges(1);
        check("R8 level not early", 6'h00);
        edges(1);
        check("R5 level low asserts", 6'h04);
        pulse_clr(2);
        check("R5 clear ignored in level", 6'h04);
        pin_i[2] = 1'b1;
        edges(3);
        check("R5 level releases", 6'h00);
    endtask

    task automatic t_rise;
        wr_ext(8'b00_00_01_00);
        edges(3);
        check("R10 rise mode with pin high", 6'h00);
        pin_i[3] = 1'b0;
        edges(4);
        check("R9 falling ignored in rise mode", 6'h00);
        pin_i[3] = 1'b1;
        edges(2);
        check("R8 edge not early", 6'h00);
        edges(1);
        check("R2 rise sets", 6'h08);
        pin_i[3] = 1'b0;
        edges(4);
        check("R6 sticky across pin activity", 6'h08);
        pulse_clr(3);
        check("R6 clear drops", 6'h00);
        pin_i[3] = 1'b1;
        edges(4);
        pulse_clr(3);
        wr_ext(8'h00);
    endtask

    task automatic t_fall;
        wr_ext(8'b00_10_00_00);
        pin_i[4] = 1'b0;
        edges(3);
        check("R2 fall sets", 6'h10);
        pulse_clr(4);
        pin_i[4] = 1'b1;
        edges(4);
        check("R9 rising ignored in fall mode", 6'h00);
        wr_ext(8'h00);
    endtask

    task automatic t_both;
        wr_ext(8'b11_00_00_00);
        pin_i[5] = 1'b0;
        edges(3);
        check("R2 both mode falling", 6'h20);
        pulse_clr(5);
        check("R6 both cleared", 6'h00);
        pin_i[5] = 1'b1;
        edges(3);
        check("R2 both mode rising", 6'h20);
        pulse_clr(5);
        wr_ext(8'h00);
        edges(2);
        check("R2 back to level", 6'h00);
    endtask

    task automatic t_ch0;
        wr_sel(2'b01);
        pin_i[0] = 1'b0;
        edges(3);
        check("R3 ch0 falling sets", 6'h01);
        pulse_clr(0);
        pin_i[0] = 1'b1;
        edges(4);
        check("R3 ch0 rising ignored", 6'h00);
        wr_sel(2'b00);
        pin_i[0] = 1'b0;
        edges(3);
        check("R3 ch0 level", 6'h01);
        pin_i[0] = 1'b1;
        edges(3);
    endtask

    task automatic t_ch1;
        wr_sel(2'b10);
        pin_i[1] = 1'b0;
        edges(3);
        check("R4 ch1 falling sets", 6'h02);
        pulse_clr(1);
        check("R4 ch1 cleared", 6'h00);
        pin_i[1] = 1'b1;
        edges(3);
        check("R4 ch1 rising sets", 6'h02);
        pulse_clr(1);
        wr_sel(2'b00);
        pin_i[1] = 1'b0;
        edges(3);
        check("R4 ch1 level", 6'h02);
        pin_i[1] = 1'b1;
        edges(3);
    endtask

    task automatic t_race;
        wr_ext(8'b00_00_00_11);
        pin_i[2] = 1'b0;
        edges(3);
        check("R7 setup set", 6'h04);
        // transition is detected between the 2nd and 3rd edge after sampling
        pin_i[2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        clr_i[2] = 1'b1;
        @(negedge clk);
        clr_i[2] = 1'b0;
        check("R7 edge beats clear", 6'h04);
        pulse_clr(2);
        check("R7 later clear works", 6'h00);
        wr_ext(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_level();
        t_rise();
        t_fall();
        t_both();
        t_ch0();
        t_ch1();
        t_race();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired req_o=%b expected=done", req_o);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule